// File: doc/BRIEF.md
# Power-Fail Protected Asynchronous SRAM Front End

This block sits between an asynchronous byte-wide memory bus and an internal storage array. The bus uses active-low chip select, write strobe and output enable, a 19-bit address and an 8-bit data path. The data path reaches the block as split pad signals: an input byte, an output byte and a drive enable for the pad ring's tristate buffer. All bus pins are brought into the system clock domain through a two-flop synchronizer. The block decodes read, write and idle from the synchronized pins. It commits a write to the array in a single cycle, once the write has ended.

A supervisor gives the block a digitized supply-good level and a flag that is high while the battery powers the part. Both are synchronized as well. A low supply-good only counts once it has lasted a programmable number of cycles, so short spikes are filtered out. A qualified failure, or a raised battery flag, puts the block into lockout. In lockout the pad drivers are off and every bus input is ignored. When supply-good comes back, the block stays locked for a programmable recovery time. Any new failure during that time sends it back to lockout.

Top module: `pfs_sram_front`

## Requirements
- R1: While reset is asserted, and from its release until supply-good has been high for the recovery time, `dq_oe` stays 0 and `arr_wr_en` never pulses, even with the bus driving a read or a write.
- R2: With the block unlocked, chip select low (0) and write strobe high (1) read the array at the bus address. `dq_oe` is 1 and `dq_o` carries the array byte only while, in addition, output enable is low; with output enable high, `dq_oe` is 0.
- R3: A write is the interval in which chip select and write strobe are both low. It is committed as exactly one `arr_wr_en` pulse after whichever of the two pins rises first. No commit occurs while both are still low. The committed byte and address are those present on the bus in the last cycle of the interval.
- R4: If a read is already driving the pads, pulling the write strobe low turns `dq_oe` off. If chip select and write strobe fall in the same cycle, `dq_oe` stays 0 for the whole access, even with output enable low.
- R5: Supply-good held low for at least GLITCH_CYC synchronized cycles, or a battery flag at 1, locks the block: `dq_oe` is 0 and bus writes do not reach the array.
- R6: A supply-good low pulse shorter than GLITCH_CYC cycles has no effect, and the next read still drives its data.
- R7: After supply-good returns high, the lockout holds for RECOVER_CYC further cycles of good supply. A qualified failure in that window restarts the lockout, and the recovery time is counted again from the next return.
- R8: A write that is still active when lockout starts, or that began before the block unlocked, is never committed. The addressed byte and every other location keep their old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_ce_n | input | 1 | Bus chip select, active low |
| bus_we_n | input | 1 | Bus write strobe, active low |
| bus_oe_n | input | 1 | Bus output enable, active low |
| bus_addr | input | 19 | Bus byte address |
| dq_i | input | 8 | Data arriving from the bus pads |
| dq_o | output | 8 | Data toward the bus pads |
| dq_oe | output | 1 | Pad drive enable; 0 means high impedance |
| pwr_good | input | 1 | Supply-good level from the supervisor, asynchronous |
| batt_on | input | 1 | High while on battery power, asynchronous |
| arr_addr | output | 19 | Array address |
| arr_wr_en | output | 1 | One-cycle array write strobe |
| arr_rd_en | output | 1 | Array read active |
| arr_wdata | output | 8 | Array write byte |
| arr_rdata | input | 8 | Array read byte, combinational from arr_addr |

## Verification
The bench builds the block with GLITCH_CYC set to 3 and RECOVER_CYC set to 20, so a complete lockout and recovery takes a few dozen cycles. At these values a recovery that restarts mid-window can be told apart from one that does not: an access placed 16 cycles after the second return lies past the first window's end but inside the restarted one. They also let a one-cycle glitch sit well below the filter threshold, and let writes that straddle the lockout boundary on either side finish within the run.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  // Protection state of the front end
  typedef enum logic [1:0] {
    PF_LOCK    = 2'd0,
    PF_RECOVER = 2'd1,
    PF_RUN     = 2'd2
  } pf_state_e;

endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pfs_guard.sv
module pfs_guard
  import pfs_pkg::*;
#(
  parameter int GLITCH_CYC  = 4,
  parameter int RECOVER_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pg_s,
  input  logic bat_s,
  output logic run
);

  localparam int GW = $clog2(GLITCH_CYC + 1);
  localparam int RW = $clog2(RECOVER_CYC + 1);
  localparam logic [GW-1:0] LOW_LIM = GW'(GLITCH_CYC);
  localparam logic [RW-1:0] REC_END = RW'(RECOVER_CYC - 1);

  pf_state_e       st_q, st_d;
  logic [GW-1:0]   low_q, low_d;
  logic [RW-1:0]   rec_q, rec_d;
  logic            fail_evt;

  // low-time filter on the supply-good level
  always_comb begin
    if (pg_s)                low_d = '0;
    else if (low_q == LOW_LIM) low_d = low_q;
    else                     low_d = low_q + 1'b1;
    fail_evt = bat_s | (low_q == LOW_LIM);
  end

  // protection state machine with recovery window
  always_comb begin
    st_d  = st_q;
    rec_d = rec_q;
    case (st_q)
      PF_LOCK: begin
        rec_d = '0;
        if (!fail_evt && pg_s) st_d = PF_RECOVER;
      end
      PF_RECOVER: begin
        if (fail_evt) begin
          st_d  = PF_LOCK;
          rec_d = '0;
        end else if (!pg_s) begin
          rec_d = '0;
        end else if (rec_q == REC_END) begin
          st_d  = PF_RUN;
          rec_d = '0;
        end else begin
          rec_d = rec_q + 1'b1;
        end
      end
      PF_RUN: begin
        if (fail_evt) st_d = PF_LOCK;
      end
      default: st_d = PF_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PF_LOCK;
      low_q <= '0;
      rec_q <= '0;
    end else begin
      st_q  <= st_d;
      low_q <= low_d;
      rec_q <= rec_d;
    end
  end

  assign run = (st_q == PF_RUN);

endmodule

// File: rtl/pfs_decode.sv
module pfs_decode #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              arr_wr_en,
  output logic              arr_rd_en,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              dq_oe
);

  logic              wr_now;
  logic              wr_prev_q;
  logic              wr_ok_q, wr_ok_d;
  logic              commit;
  logic [ADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0] wdata_q;

  assign wr_now = ~ce_n & ~we_n;

  // a write is eligible only if it started while unlocked
  always_comb begin
    commit  = run & wr_ok_q & wr_prev_q & ~wr_now;
    wr_ok_d = wr_ok_q;
    if (!run)                    wr_ok_d = 1'b0;
    else if (wr_now && !wr_prev_q) wr_ok_d = 1'b1;
    else if (!wr_now)            wr_ok_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev_q <= 1'b0;
      wr_ok_q   <= 1'b0;
    end else begin
      wr_prev_q <= wr_now;
      wr_ok_q   <= wr_ok_d;
    end
  end

  // keep the bus values of the latest active write cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      wdata_q <= '0;
    end else if (wr_now) begin
      waddr_q <= addr;
      wdata_q <= wdata;
    end
  end

  always_comb begin
    arr_wr_en = commit;
    arr_addr  = commit ? waddr_q : addr;
    arr_wdata = wdata_q;
    arr_rd_en = run & ~commit & ~ce_n & we_n;
    dq_oe     = arr_rd_en & ~oe_n;
  end

endmodule

// File: rtl/pfs_sram_front.sv
module pfs_sram_front #(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_CYC  = 4,
  parameter int RECOVER_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  input  logic              pwr_good,
  input  logic              batt_on,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              arr_wr_en,
  output logic              arr_rd_en,
  output logic [DATA_W-1:0] arr_wdata,
  input  logic [DATA_W-1:0] arr_rdata
);

  localparam int BUS_W = 3 + ADDR_W + DATA_W;
  localparam logic [BUS_W-1:0] BUS_IDLE = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

  logic [BUS_W-1:0]  bus_s;
  logic [1:0]        sup_s;
  logic              ce_s, we_s, oe_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic              run;

  pfs_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) i_bus_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bus_ce_n, bus_we_n, bus_oe_n, bus_addr, dq_i}),
    .q     (bus_s)
  );

  pfs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) i_sup_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pwr_good, batt_on}),
    .q     (sup_s)
  );

  assign {ce_s, we_s, oe_s, addr_s, data_s} = bus_s;

  pfs_guard #(.GLITCH_CYC(GLITCH_CYC), .RECOVER_CYC(RECOVER_CYC)) i_guard (
    .clk   (clk),
    .rst_n (rst_n),
    .pg_s  (sup_s[1]),
    .bat_s (sup_s[0]),
    .run   (run)
  );

  pfs_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .ce_n      (ce_s),
    .we_n      (we_s),
    .oe_n      (oe_s),
    .addr      (addr_s),
    .wdata     (data_s),
    .arr_addr  (arr_addr),
    .arr_wr_en (arr_wr_en),
    .arr_rd_en (arr_rd_en),
    .arr_wdata (arr_wdata),
    .dq_oe     (dq_oe)
  );

  assign dq_o = dq_oe ? arr_rdata : '0;

endmodule

// File: rtl/pfs_sram_front_chk.sv
module pfs_sram_front_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_oe_n,
  input logic batt_on,
  input logic dq_oe,
  input logic arr_wr_en,
  input logic run
);

  // R2
  oe_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe_n && $past(bus_oe_n) && $past(bus_oe_n, 2)) |-> !dq_oe);

  // R3
  single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |=> !arr_wr_en);

  // R4
  drive_or_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_wr_en, dq_oe}));

  // R5
  locked_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |-> run);

  // R5
  locked_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> run);

  // R5
  battery_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_on && $past(batt_on) && $past(batt_on, 2) && $past(batt_on, 3)) |-> !run);

endmodule

bind pfs_sram_front pfs_sram_front_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_oe_n  (bus_oe_n),
  .batt_on   (batt_on),
  .dq_oe     (dq_oe),
  .arr_wr_en (arr_wr_en),
  .run       (run)
);

// File: tb/test_pfs_sram_front.sv
module test_pfs_sram_front;

  localparam int AW = 19;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          ce_n, we_n, oe_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dq_o;
  logic          dq_oe;
  logic          pg, bat;
  logic [AW-1:0] arr_addr;
  logic          arr_wr_en, arr_rd_en;
  logic [DW-1:0] arr_wdata;
  logic [DW-1:0] arr_rdata;

  int            n_chk;
  int            n_err;
  int            wr_cnt;
  logic [AW-1:0] last_a;
  logic [DW-1:0] last_d;
  logic [DW-1:0] mem [256];

  pfs_sram_front #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2),
                   .GLITCH_CYC(3), .RECOVER_CYC(20)) i_pfs_sram_front (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
    .bus_addr(addr), .dq_i(din), .dq_o(dq_o), .dq_oe(dq_oe), .pwr_good(pg),
    .batt_on(bat), .arr_addr(arr_addr), .arr_wr_en(arr_wr_en),
    .arr_rd_en(arr_rd_en), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // array model (indexed by the low address byte) with write log
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    wr_cnt = 0;
    last_a = '0;
    last_d = '0;
  end
  always @(posedge clk) begin
    if (arr_wr_en) begin
      mem[arr_addr[7:0]] <= arr_wdata;
      wr_cnt <= wr_cnt + 1;
      last_a <= arr_addr;
      last_d <= arr_wdata;
    end
  end
  assign arr_rdata = mem[arr_addr[7:0]];

  // {is_write, address, write data, expected read data}
  localparam logic [35:0] VEC [8] = '{
    {1'b1, 19'h7FF10, 8'hC3, 8'h00},
    {1'b1, 19'h00011, 8'h5A, 8'h00},
    {1'b1, 19'h2A512, 8'h0F, 8'h00},
    {1'b0, 19'h7FF10, 8'h00, 8'hC3},
    {1'b0, 19'h00011, 8'h00, 8'h5A},
    {1'b1, 19'h7FF10, 8'hE1, 8'h00},
    {1'b0, 19'h7FF10, 8'h00, 8'hE1},
    {1'b0, 19'h2A512, 8'h00, 8'h0F}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_idle();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit ce_ends);
    addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0;
    wait_n(1);
    we_n = 1'b0;
    wait_n(4);
    if (ce_ends) ce_n = 1'b1; else we_n = 1'b1;
    wait_n(1);
    bus_idle();
    wait_n(4);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic oe, output logic [DW-1:0] d);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    wait_n(4);
    oe = dq_oe;
    d  = dq_o;
    bus_idle();
    wait_n(3);
  endtask

  logic          r_oe;
  logic [DW-1:0] r_d;
  int            cnt0;
  int            drv;
  logic          done;

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; pg = 1'b1; bat = 1'b0;
    addr = '0; din = '0;
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    wait_n(5);
    // R1: reset with a read driven on the bus
    check("R1 reset dq_oe", dq_oe, 0);
    check("R1 reset arr_wr_en", arr_wr_en, 0);
    bus_idle();
    @(posedge clk); #1 rst_n = 1'b1;
    wait_n(1);
    // R1: still inside the start-up recovery window
    bus_read(19'h00000, r_oe, r_d);
    check("R1 startup locked", r_oe, 0);
    wait_n(40);

    // R2 / R3: table of writes and reads
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][35]) begin
        bus_write(VEC[i][34:16], VEC[i][15:8], 1'b0);
      end else begin
        bus_read(VEC[i][34:16], r_oe, r_d);
        check($sformatf("R2 vec%0d drive", i), r_oe, 1);
        check($sformatf("R2 vec%0d data", i), r_d, VEC[i][7:0]);
      end
    end

    // R2: output enable high keeps the pads off
    addr = 19'h7FF10; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b1;
    wait_n(4);
    check("R2 oe high no drive", dq_oe, 0);
    bus_idle(); wait_n(3);

    // R3: commit happens on the terminating edge with the last data
    cnt0 = wr_cnt;
    addr = 19'h00040; din = 8'h11; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    wait_n(3);
    din = 8'h22;
    wait_n(3);
    check("R3 no commit while active", wr_cnt, cnt0);
    we_n = 1'b1;
    wait_n(4);
    ce_n = 1'b1;
    wait_n(2);
    check("R3 one commit", wr_cnt, cnt0 + 1);
    check("R3 commit data", last_d, 8'h22);
    check("R3 commit addr", last_a, 19'h00040);

    // R3: chip-select terminated write
    bus_write(19'h00041, 8'h5A, 1'b1);
    bus_read(19'h00041, r_oe, r_d);
    check("R3 ce-ended write", r_d, 8'h5A);

    // R4: write strobe falling during an active read switches drive off
    addr = 19'h00050; din = 8'h77; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    wait_n(4);
    check("R4 read drives", dq_oe, 1);
    we_n = 1'b0;
    wait_n(3);
    check("R4 we low turns off", dq_oe, 0);
    we_n = 1'b1;
    wait_n(1);
    bus_idle(); wait_n(4);
    bus_read(19'h00050, r_oe, r_d);
    check("R4 write after read", r_d, 8'h77);

    // R4: chip select and write strobe fall together
    drv = 0;
    addr = 19'h00051; din = 8'h33; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      wait_n(1);
      if (dq_oe) drv++;
    end
    check("R4 simultaneous fall no drive", drv, 0);
    bus_idle(); wait_n(4);

    // R6: one-cycle supply glitch is ignored
    pg = 1'b0; wait_n(1); pg = 1'b1;
    bus_read(19'h00051, r_oe, r_d);
    check("R6 glitch ignored drive", r_oe, 1);
    check("R6 glitch ignored data", r_d, 8'h33);

    // R5: qualified failure locks; writes ignored
    pg = 1'b0; wait_n(10);
    bus_read(19'h00051, r_oe, r_d);
    check("R5 locked no drive", r_oe, 0);
    cnt0 = wr_cnt;
    bus_write(19'h00051, 8'hAA, 1'b0);
    check("R5 locked write ignored", wr_cnt, cnt0);

    // R7: early in recovery access is still blocked
    pg = 1'b1; wait_n(2);
    bus_read(19'h00051, r_oe, r_d);
    check("R7 recovery blocks read", r_oe, 0);
    bus_write(19'h00051, 8'hBB, 1'b0);
    check("R7 recovery blocks write", wr_cnt, cnt0);
    wait_n(40);
    bus_read(19'h00051, r_oe, r_d);
    check("R7 resumed drive", r_oe, 1);
    check("R7 old data kept", r_d, 8'h33);

    // R7: failure during recovery restarts the window
    pg = 1'b0; wait_n(10);
    pg = 1'b1; wait_n(12);
    pg = 1'b0; wait_n(8);
    pg = 1'b1; wait_n(12);
    bus_read(19'h00051, r_oe, r_d);
    check("R7 restarted window blocks", r_oe, 0);
    wait_n(30);
    bus_read(19'h00051, r_oe, r_d);
    check("R7 after restart drives", r_oe, 1);

    // R8: write cut by power failure is dropped
    cnt0 = wr_cnt;
    addr = 19'h00060; din = 8'h9C; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    wait_n(3);
    pg = 1'b0; wait_n(10);
    we_n = 1'b1; wait_n(1); ce_n = 1'b1;
    pg = 1'b1; wait_n(40);
    check("R8 interrupted write dropped", wr_cnt, cnt0);
    bus_read(19'h00060, r_oe, r_d);
    check("R8 interrupted addr unchanged", r_d, 8'h00);

    // R8: write begun in lockout and ended after unlock is dropped
    pg = 1'b0; wait_n(10);
    addr = 19'h00061; din = 8'h4D; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    wait_n(2);
    pg = 1'b1; wait_n(40);
    we_n = 1'b1; wait_n(1); ce_n = 1'b1; wait_n(4);
    check("R8 straddling write dropped", wr_cnt, cnt0);
    bus_read(19'h00061, r_oe, r_d);
    check("R8 straddling addr unchanged", r_d, 8'h00);
    bus_read(19'h00040, r_oe, r_d);
    check("R8 other location kept", r_d, 8'h22);

    // R5: battery flag locks even with supply good
    bat = 1'b1; wait_n(6);
    bus_read(19'h00040, r_oe, r_d);
    check("R5 battery locks", r_oe, 0);
    bat = 1'b0; wait_n(40);
    bus_read(19'h00040, r_oe, r_d);
    check("R5 battery release drives", r_oe, 1);
    check("R5 battery release data", r_d, 8'h22);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule